// File: doc/BRIEF.md
# Dual-Strobe Up/Down Counter

This block is a presettable binary counter with two separate count strobes: a rising edge on the up strobe adds one to the count and a rising edge on the down strobe subtracts one. A master clear forces the count to zero. An active-low load copies a data word into the count. Two active-low terminal outputs follow the low phase of the strobe that is active while the count sits at its limit. Each one can drive a strobe of the next stage, so several stages chain into a wider counter.

Both strobes may come from outside the system clock domain. Each passes through a parameterised synchronizer, and an edge detector turns it into a one-cycle rise pulse. Clear and load are synchronous to the system clock. Each takes effect on the next clock edge and keeps priority for as long as it is held. Clear ranks above load, and load ranks above counting. The count width and the synchronizer depth are parameters.

Top module: `dual_strobe_counter`

## Requirements
- R1: An up-strobe rise while the down strobe is high adds one to the count. A down-strobe rise while the up strobe is high subtracts one.
- R2: `carry_n` is low exactly when the count is all ones and the synchronized up strobe is low. Otherwise it is high, and it returns high once the up strobe is high again.
- R3: `borrow_n` is low exactly when the count is zero and the synchronized down strobe is low. Otherwise it is high.
- R4: While `clear` is high, the count is forced to zero on every clock edge, ignoring `load_n` and both strobes.
- R5: While `load_n` is low and `clear` is low, `data` is copied into the count on every clock edge, and strobe edges have no effect.
- R6: Counting up from all ones gives zero, and counting down from zero gives all ones.
- R7: When a stage's `carry_n` drives the next stage's up strobe and its `borrow_n` drives the next stage's down strobe, two stages count as one counter of twice the width.
- R8: A strobe that is low during a clear or a load and stays low afterwards has its next rise counted normally.
- R9: While `rst_n` is low, the count is zero and both terminal outputs are high.
- R10: If both strobes rise in the same clock cycle, the count holds its value.
- R11: A strobe rise while the other strobe is low does not change the count.
- R12: With the default two synchronizer stages, the count changes on the third rising clock edge after a strobe rises, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all state changes on its rising edge |
| rst_n | input | 1 | Active-low asynchronous system reset |
| up_strobe | input | 1 | Up-count strobe; counts on its rising edge |
| dn_strobe | input | 1 | Down-count strobe; counts on its rising edge |
| clear | input | 1 | Master clear, active high, highest priority |
| load_n | input | 1 | Parallel load, active low |
| data | input | WIDTH | Parallel preset value |
| count | output | WIDTH | Current count |
| carry_n | output | 1 | Active-low terminal count upward |
| borrow_n | output | 1 | Active-low terminal count downward |

## Verification
The bound checker checks the following on every clock cycle:
- outside clear and load, the count moves by at most one step;
- clear gives zero;
- load gives the sampled data word;
- a terminal output goes low only at the matching limit count;
- a double rise, or a rise while the other strobe is low, leaves the count unchanged.

Other behaviour appears only in the bench's scenarios, where two cascaded instances are compared with an 8-bit reference model:
- the cascaded carry and borrow chain;
- wrap-around at the 8-bit limits;
- a strobe held low through a clear still being counted afterwards;
- the exact three-edge latency from a strobe rise to a count change.

// File: rtl/dsc_pkg.sv
package dsc_pkg;

   typedef enum logic [2:0] {
      ACT_HOLD  = 3'd0,
      ACT_INC   = 3'd1,
      ACT_DEC   = 3'd2,
      ACT_LOAD  = 3'd3,
      ACT_CLEAR = 3'd4
   } cnt_act_e;

   // Priority: clear, then load, then counting. A double rise or a rise
   // while the opposite strobe is low leaves the count untouched.
   function automatic cnt_act_e pick_action(
      input logic clr,
      input logic ld_n,
      input logic up_rise,
      input logic dn_rise,
      input logic up_high,
      input logic dn_high
   );
      cnt_act_e a;
      if (clr)                        a = ACT_CLEAR;
      else if (!ld_n)                 a = ACT_LOAD;
      else if (up_rise && dn_rise)    a = ACT_HOLD;
      else if (up_rise && dn_high)    a = ACT_INC;
      else if (dn_rise && up_high)    a = ACT_DEC;
      else                            a = ACT_HOLD;
      return a;
   endfunction

endpackage

// File: rtl/dsc_sync.sv
module dsc_sync #(
   parameter int   STAGES = 2,
   parameter logic IDLE   = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES < 1) begin : g_bad_depth
         $error("dsc_sync: STAGES must be at least 1");
      end
      if (STAGES == 1) begin : g_single
         logic stage_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q <= IDLE;
            else        stage_q <= d;
         end
         assign q = stage_q;
      end else begin : g_chain
         logic [STAGES-1:0] pipe_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pipe_q <= {STAGES{IDLE}};
            else        pipe_q <= {pipe_q[STAGES-2:0], d};
         end
         assign q = pipe_q[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/dsc_edge.sv
module dsc_edge #(
   parameter logic IDLE = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl,
   output logic rise
);
   logic prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= IDLE;
      else        prev_q <= lvl;
   end

   assign rise = lvl & ~prev_q;
endmodule

// File: rtl/dsc_count.sv
module dsc_count #(
   parameter int WIDTH = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  dsc_pkg::cnt_act_e act,
   input  logic [WIDTH-1:0]  preset,
   output logic [WIDTH-1:0]  value
);
   localparam logic [WIDTH-1:0] STEP = WIDTH'(1);

   logic [WIDTH-1:0] next_value;

   always_comb begin
      unique case (act)
         dsc_pkg::ACT_CLEAR: next_value = '0;
         dsc_pkg::ACT_LOAD:  next_value = preset;
         dsc_pkg::ACT_INC:   next_value = value + STEP;
         dsc_pkg::ACT_DEC:   next_value = value - STEP;
         default:            next_value = value;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) value <= '0;
      else        value <= next_value;
   end
endmodule

// File: rtl/dsc_term.sv
module dsc_term #(
   parameter int WIDTH = 4
) (
   input  logic [WIDTH-1:0] value,
   input  logic             up_lvl,
   input  logic             dn_lvl,
   output logic             carry_n,
   output logic             borrow_n
);
   localparam logic [WIDTH-1:0] TOP_VALUE = {WIDTH{1'b1}};

   logic at_top;
   logic at_bottom;

   assign at_top    = (value == TOP_VALUE);
   assign at_bottom = (value == '0);
   assign carry_n   = ~(at_top & ~up_lvl);
   assign borrow_n  = ~(at_bottom & ~dn_lvl);
endmodule

// File: rtl/dual_strobe_counter.sv
module dual_strobe_counter #(
   parameter int WIDTH       = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             up_strobe,
   input  logic             dn_strobe,
   input  logic             clear,
   input  logic             load_n,
   input  logic [WIDTH-1:0] data,
   output logic [WIDTH-1:0] count,
   output logic             carry_n,
   output logic             borrow_n
);
   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("dual_strobe_counter: WIDTH must be at least 2");
      end
      if (SYNC_STAGES < 1) begin : g_bad_sync
         $error("dual_strobe_counter: SYNC_STAGES must be at least 1");
      end
   endgenerate

   logic              up_lvl;
   logic              dn_lvl;
   logic              rise_up;
   logic              rise_dn;
   dsc_pkg::cnt_act_e act;

   dsc_sync #(.STAGES(SYNC_STAGES), .IDLE(1'b1)) up_sync_i (
      .clk(clk), .rst_n(rst_n), .d(up_strobe), .q(up_lvl)
   );
   dsc_sync #(.STAGES(SYNC_STAGES), .IDLE(1'b1)) dn_sync_i (
      .clk(clk), .rst_n(rst_n), .d(dn_strobe), .q(dn_lvl)
   );

   dsc_edge #(.IDLE(1'b1)) up_edge_i (
      .clk(clk), .rst_n(rst_n), .lvl(up_lvl), .rise(rise_up)
   );
   dsc_edge #(.IDLE(1'b1)) dn_edge_i (
      .clk(clk), .rst_n(rst_n), .lvl(dn_lvl), .rise(rise_dn)
   );

   always_comb begin
      act = dsc_pkg::pick_action(clear, load_n, rise_up, rise_dn, up_lvl, dn_lvl);
   end

   dsc_count #(.WIDTH(WIDTH)) count_i (
      .clk(clk), .rst_n(rst_n), .act(act), .preset(data), .value(count)
   );

   dsc_term #(.WIDTH(WIDTH)) term_i (
      .value(count), .up_lvl(up_lvl), .dn_lvl(dn_lvl),
      .carry_n(carry_n), .borrow_n(borrow_n)
   );
endmodule

// File: rtl/dsc_checker.sv
module dsc_checker #(
   parameter int WIDTH = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             clear,
   input logic             load_n,
   input logic [WIDTH-1:0] data,
   input logic [WIDTH-1:0] count,
   input logic             carry_n,
   input logic             borrow_n,
   input logic             up_lvl,
   input logic             dn_lvl,
   input logic             rise_up,
   input logic             rise_dn
);
   localparam logic [WIDTH-1:0] ONE  = WIDTH'(1);
   localparam logic [WIDTH-1:0] MAXV = {WIDTH{1'b1}};

   // R1 / R6: outside clear and load the count moves by at most one step
   p_single_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (!clear && load_n) |=> (count == $past(count) ||
                              count == $past(count) + ONE ||
                              count == $past(count) - ONE));

   p_carry_limit_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !carry_n |-> (count == MAXV && !up_lvl));

   p_borrow_limit_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !borrow_n |-> (count == '0 && !dn_lvl));

   p_clear_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> (count == '0));

   p_load_copy_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!clear && !load_n) |=> (count == $past(data)));

   p_double_rise_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (rise_up && rise_dn && !clear && load_n) |=> $stable(count));

   p_up_ignored_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (rise_up && !rise_dn && !dn_lvl && !clear && load_n) |=> $stable(count));

   p_dn_ignored_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (rise_dn && !rise_up && !up_lvl && !clear && load_n) |=> $stable(count));
endmodule

bind dual_strobe_counter dsc_checker #(.WIDTH(WIDTH)) chk_i (
   .clk(clk), .rst_n(rst_n), .clear(clear), .load_n(load_n), .data(data),
   .count(count), .carry_n(carry_n), .borrow_n(borrow_n),
   .up_lvl(up_lvl), .dn_lvl(dn_lvl), .rise_up(rise_up), .rise_dn(rise_dn)
);

// File: tb/dual_strobe_counter_tb_top.sv
module dual_strobe_counter_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       up_s = 1'b1;
   logic       dn_s = 1'b1;
   logic       clear = 1'b0;
   logic       load_n = 1'b1;
   logic [3:0] data_lo = '0;
   logic [3:0] data_hi = '0;
   logic [3:0] cnt_lo, cnt_hi;
   logic       carry_lo_n, borrow_lo_n, carry_hi_n, borrow_hi_n;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;
   logic [7:0] ref_cnt = '0;

   always #10 clk = ~clk;

   dual_strobe_counter dut_i (
      .clk(clk), .rst_n(rst_n), .up_strobe(up_s), .dn_strobe(dn_s),
      .clear(clear), .load_n(load_n), .data(data_lo),
      .count(cnt_lo), .carry_n(carry_lo_n), .borrow_n(borrow_lo_n)
   );

   // R7: second stage strobed by the first stage's terminal outputs
   dual_strobe_counter dut_hi_i (
      .clk(clk), .rst_n(rst_n), .up_strobe(carry_lo_n), .dn_strobe(borrow_lo_n),
      .clear(clear), .load_n(load_n), .data(data_hi),
      .count(cnt_hi), .carry_n(carry_hi_n), .borrow_n(borrow_hi_n)
   );

   function automatic logic [7:0] step_up(logic [7:0] v);
      return v + 8'd1;
   endfunction
   function automatic logic [7:0] step_dn(logic [7:0] v);
      return v - 8'd1;
   endfunction

   task automatic cyc(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic int full();
      return int'({cnt_hi, cnt_lo});
   endfunction
   function automatic int terms();
      return int'({carry_hi_n, borrow_hi_n, carry_lo_n, borrow_lo_n});
   endfunction

   task automatic pulse_up();
      up_s = 1'b0; cyc(6); up_s = 1'b1; cyc(10);
      ref_cnt = step_up(ref_cnt);
   endtask
   task automatic pulse_dn();
      dn_s = 1'b0; cyc(6); dn_s = 1'b1; cyc(10);
      ref_cnt = step_dn(ref_cnt);
   endtask
   task automatic do_load(logic [7:0] v);
      data_lo = v[3:0]; data_hi = v[7:4];
      load_n = 1'b0; cyc(6); load_n = 1'b1; cyc(6);
      ref_cnt = v;
   endtask
   task automatic do_clear();
      clear = 1'b1; cyc(6); clear = 1'b0; cyc(4);
      ref_cnt = '0;
   endtask

   initial begin
      void'($urandom(32'd20240611));
      cyc(4);
      chk("R9 count in reset", full(), 0);
      chk("R9 terminals in reset", terms(), 4'hF);
      rst_n = 1'b1;
      cyc(4);
      chk("R9 count after reset", full(), 0);

      // R1 basic up and down
      pulse_up(); chk("R1 up", full(), ref_cnt);
      pulse_dn(); chk("R1 down", full(), ref_cnt);

      // R7 cascade across the nibble boundary
      do_load(8'h0F); pulse_up(); chk("R7 carry into upper stage", full(), 8'h10);
      pulse_dn(); chk("R7 borrow from upper stage", full(), 8'h0F);

      // R6 wrap
      do_load(8'hFF); pulse_up(); chk("R6 wrap up", full(), 8'h00);
      pulse_dn(); chk("R6 wrap down", full(), 8'hFF);

      // R2 terminal count up, idle and active
      do_load(8'hFF);
      chk("R2 carry high with up strobe high", terms(), 4'hF);
      up_s = 1'b0; cyc(8);
      chk("R2 carry low at top with strobe low", int'(carry_lo_n), 0);
      chk("R2 cascaded carry low", int'(carry_hi_n), 0);
      up_s = 1'b1; cyc(10); ref_cnt = 8'h00;
      chk("R2 carry released, count wrapped", full(), ref_cnt);
      chk("R2 carry high again", terms(), 4'hF);

      // R3 terminal count down
      do_load(8'h00);
      dn_s = 1'b0; cyc(8);
      chk("R3 borrow low at zero", int'(borrow_lo_n), 0);
      chk("R3 cascaded borrow low", int'(borrow_hi_n), 0);
      dn_s = 1'b1; cyc(10); ref_cnt = 8'hFF;
      chk("R3 borrow released, count wrapped", full(), ref_cnt);

      // R4 clear beats load and strobes
      do_load(8'h5A);
      data_lo = 4'hA; data_hi = 4'hA;
      clear = 1'b1; load_n = 1'b0; up_s = 1'b0; cyc(4);
      chk("R4 clear over load", full(), 0);
      up_s = 1'b1; cyc(6);
      chk("R4 clear over strobe", full(), 0);
      clear = 1'b0; load_n = 1'b1; cyc(4); ref_cnt = '0;

      // R5 load ignores strobes
      data_lo = 4'hC; data_hi = 4'h3;
      load_n = 1'b0; cyc(2);
      up_s = 1'b0; cyc(3); up_s = 1'b1; cyc(3);
      dn_s = 1'b0; cyc(3); dn_s = 1'b1; cyc(6);
      chk("R5 load holds data during strobes", full(), 8'h3C);
      load_n = 1'b1; cyc(6); ref_cnt = 8'h3C;
      chk("R5 loaded value kept", full(), ref_cnt);

      // R8 strobe held low through clear is counted
      up_s = 1'b0; cyc(4);
      do_clear();
      chk("R8 cleared with up low", full(), 0);
      up_s = 1'b1; cyc(10); ref_cnt = 8'h01;
      chk("R8 edge after clear counted", full(), ref_cnt);

      // R8 strobe held low through load is counted
      dn_s = 1'b0; cyc(4);
      do_load(8'h27);
      dn_s = 1'b1; cyc(10); ref_cnt = 8'h26;
      chk("R8 edge after load counted", full(), ref_cnt);

      // R10 simultaneous rises hold
      do_load(8'h47);
      up_s = 1'b0; dn_s = 1'b0; cyc(6);
      up_s = 1'b1; dn_s = 1'b1; cyc(10);
      chk("R10 double rise holds", full(), 8'h47);

      // R11 up rise with down low ignored, then down rise decrements (R1)
      do_load(8'h35);
      dn_s = 1'b0; cyc(6);
      up_s = 1'b0; cyc(6); up_s = 1'b1; cyc(10);
      chk("R11 up rise ignored while down low", full(), 8'h35);
      dn_s = 1'b1; cyc(10); ref_cnt = 8'h34;
      chk("R1 down rise with up high", full(), ref_cnt);

      // R12 latency
      up_s = 1'b0; cyc(6);
      up_s = 1'b1; cyc(2);
      chk("R12 unchanged after two edges", full(), ref_cnt);
      cyc(1); ref_cnt = step_up(ref_cnt);
      chk("R12 changed on third edge", full(), ref_cnt);
      cyc(8);

      // Random mix against the reference model
      for (int i = 0; i < 250; i++) begin
         int sel = $urandom_range(0, 9);
         if (sel < 4)       pulse_up();
         else if (sel < 8)  pulse_dn();
         else if (sel == 8) do_load(8'($urandom_range(0, 255)));
         else               do_clear();
         chk("R7 random cascaded count", full(), ref_cnt);
         chk("R2 R3 terminals idle high", terms(), 4'hF);
      end

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule